// File: doc/BRIEF.md
# Unconditional-Jump Subfunction Decoder with Privilege Gate

This block sits in the decode stage of a 36-bit processor. When the unconditional-jump opcode is issued, the 4-bit accumulator field selects one of eleven jump flavours. These include a plain jump, halt, flag restore, interrupt dismiss and program-counter-word exchange. The block reports which flavour was chosen as a one-hot vector. If the code is unassigned, or if the current mode flags forbid the flavour, it raises a strobe that traps to the monitor instead.

A rule-set input picks between two privilege models. The basic model checks only the user and user-I/O flags. The full model also takes the public flag into account. A separate input reports that the program counter lies outside address section zero, which forbids the two in-section flag-restore forms. Each decision is registered and appears exactly one clock after the instruction strobe. In that same cycle, the halt and interrupt-dismiss requests accompany a legal selection.

Top module: `jmpdec_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0.
- R2: Outputs are valid exactly one cycle after `insn_valid`. In any cycle not preceded by `insn_valid`, every output is 0.
- R3: Codes map to one-hot bits as follows: 0→bit0 plain jump, 1→bit1 clear-public jump, 2→bit2 restore flags, 4→bit3 halt, 5→bit4 extended restore, 6→bit5 extended restore with dismiss, 7→bit6 PC-word exchange, 8→bit7 dismiss and jump, 10→bit8 dismiss with restore, 12→bit9 save flags, 13→bit10 indirect global jump.
- R4: Codes 3, 9, 11, 14 and 15 always raise `trap`.
- R5: For each valid decode, exactly one of "`sel` has one bit set" and "`trap`" holds. When `trap` is raised, `sel` is 0.
- R6: Code 4 is legal only when `user` is 0 and, under the full rules, `public` is also 0. A legal halt raises `halt_req`; otherwise the decode traps.
- R7: Codes 8 and 10 trap when `user` is 1 and `uio` is 0. Under the full rules they also trap when `user` is 0 and `public` is 1. When legal, they raise `dismiss_req`.
- R8: Codes 6 and 7 trap under the basic rules when `user` is 1. Under the full rules they follow the same condition as R7. A legal code 6 raises `dismiss_req`.
- R9: Code 12 traps under the basic rules when `user` is 1, and is always legal under the full rules.
- R10: Codes 2 and 10 trap whenever `nz_section` is 1.
- R11: Codes 0, 1, 5 and 13 are legal in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Jump instruction present this cycle |
| sub_code | input | 4 | Accumulator-field subfunction code |
| user | input | 1 | User mode flag |
| uio | input | 1 | User-I/O flag |
| public | input | 1 | Public mode flag |
| nz_section | input | 1 | PC is in a non-zero address section |
| rule_full | input | 1 | 1 = full rule set, 0 = basic rule set |
| out_valid | output | 1 | Decode result valid |
| sel | output | 11 | One-hot flavour select |
| trap | output | 1 | Trap-to-monitor strobe |
| dismiss_req | output | 1 | Dismiss current interrupt |
| halt_req | output | 1 | Halt processor |

## Verification
Code 10 can be denied in the same cycle for two unrelated reasons: the mode rule of R7 and the section rule of R10. The bench sweeps every code against all flag combinations under both rule sets, so both causes are applied together, each alone, and neither. A single trap, with no dismiss request, is expected whenever either cause holds. Back-to-back strobes with random codes check that one decode's dismiss or halt request never leaks into the next cycle.

// File: rtl/jmpdec_pkg.sv
package jmpdec_pkg;
  localparam int CODE_W  = 4;
  localparam int NUM_VAR = 11;

  // one-hot bit positions of the jump flavours
  localparam int V_JUMP    = 0;
  localparam int V_CLRPUB  = 1;
  localparam int V_RSTF    = 2;
  localparam int V_HALT    = 3;
  localparam int V_XRSTF   = 4;
  localparam int V_XRSTDIS = 5;
  localparam int V_XPCW    = 6;
  localparam int V_DISMISS = 7;
  localparam int V_DISRST  = 8;
  localparam int V_SAVEF   = 9;
  localparam int V_GJUMP   = 10;

  typedef struct packed {
    logic user;
    logic uio;
    logic pub;
    logic nzsect;
  } mode_t;

  function automatic int code_of(input int v);
    case (v)
      V_JUMP:    return 0;
      V_CLRPUB:  return 1;
      V_RSTF:    return 2;
      V_HALT:    return 4;
      V_XRSTF:   return 5;
      V_XRSTDIS: return 6;
      V_XPCW:    return 7;
      V_DISMISS: return 8;
      V_DISRST:  return 10;
      V_SAVEF:   return 12;
      default:   return 13;
    endcase
  endfunction
endpackage

// File: rtl/jmpdec_classify.sv
module jmpdec_classify
  import jmpdec_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NV = NUM_VAR
) (
  input  logic [CW-1:0] code,
  output logic [NV-1:0] raw_sel,
  output logic          undefined
);
  for (genvar v = 0; v < NV; v++) begin : g_match
    localparam logic [CW-1:0] MATCH = CW'(code_of(v));
    assign raw_sel[v] = (code == MATCH);
  end

  assign undefined = ~|raw_sel;

  always_comb begin
    // R3
    assert ($countones(raw_sel) <= 1) else $error("decode_unique_chk");
  end
endmodule

// File: rtl/jmpdec_permit.sv
module jmpdec_permit
  import jmpdec_pkg::*;
#(
  parameter int NV = NUM_VAR
) (
  input  logic [NV-1:0] raw_sel,
  input  mode_t         mode,
  input  logic          rule_full,
  output logic          deny
);
  logic io_bad, halt_bad, exec_bad, save_bad;

  always_comb begin
    io_bad   = (mode.user & ~mode.uio) | (rule_full & ~mode.user & mode.pub);
    halt_bad = mode.user | (rule_full & mode.pub);
    exec_bad = rule_full ? io_bad : mode.user;
    save_bad = ~rule_full & mode.user;
    deny = (raw_sel[V_HALT] & halt_bad)
         | ((raw_sel[V_DISMISS] | raw_sel[V_DISRST]) & io_bad)
         | ((raw_sel[V_XRSTDIS] | raw_sel[V_XPCW]) & exec_bad)
         | (raw_sel[V_SAVEF] & save_bad)
         | ((raw_sel[V_RSTF] | raw_sel[V_DISRST]) & mode.nzsect);
  end

  always_comb begin
    // R11
    assert (!(deny && (raw_sel[V_JUMP] || raw_sel[V_CLRPUB] ||
                       raw_sel[V_XRSTF] || raw_sel[V_GJUMP])))
      else $error("always_legal_chk");
  end
endmodule

// File: rtl/jmpdec_outreg.sv
module jmpdec_outreg
  import jmpdec_pkg::*;
#(
  parameter int NV = NUM_VAR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NV-1:0] sel_d,
  input  logic          trap_d,
  input  logic          dis_d,
  input  logic          halt_d,
  output logic          vld_q,
  output logic [NV-1:0] sel_q,
  output logic          trap_q,
  output logic          dis_q,
  output logic          halt_q
);
  logic [NV-1:0] sel_n;
  logic          trap_n, dis_n, halt_n;

  always_comb begin
    sel_n  = '0;
    trap_n = 1'b0;
    dis_n  = 1'b0;
    halt_n = 1'b0;
    if (en) begin
      sel_n  = sel_d;
      trap_n = trap_d;
      dis_n  = dis_d;
      halt_n = halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sel_q  <= '0;
      trap_q <= 1'b0;
      dis_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      vld_q  <= en;
      sel_q  <= sel_n;
      trap_q <= trap_n;
      dis_q  <= dis_n;
      halt_q <= halt_n;
    end
  end

  // R5
  one_of_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (($countones(sel_q) == 1) != trap_q));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> (sel_q == '0 && !trap_q && !dis_q && !halt_q));
  // R6
  halt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> sel_q[V_HALT]);
  // R7
  dismiss_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> (sel_q[V_DISMISS] | sel_q[V_DISRST] | sel_q[V_XRSTDIS]));
endmodule

// File: rtl/jmpdec_top.sv
module jmpdec_top
  import jmpdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [CODE_W-1:0]  sub_code,
  input  logic               user,
  input  logic               uio,
  input  logic               public,
  input  logic               nz_section,
  input  logic               rule_full,
  output logic               out_valid,
  output logic [NUM_VAR-1:0] sel,
  output logic               trap,
  output logic               dismiss_req,
  output logic               halt_req
);
  logic [NUM_VAR-1:0] raw_sel, sel_d;
  logic               undefined, deny, trap_d, dis_d, halt_d;
  mode_t              mode;

  assign mode = '{user: user, uio: uio, pub: public, nzsect: nz_section};

  jmpdec_classify #(.CW(CODE_W), .NV(NUM_VAR)) u_cls (
    .code(sub_code), .raw_sel(raw_sel), .undefined(undefined)
  );

  jmpdec_permit #(.NV(NUM_VAR)) u_perm (
    .raw_sel(raw_sel), .mode(mode), .rule_full(rule_full), .deny(deny)
  );

  always_comb begin
    trap_d = undefined | deny;
    sel_d  = trap_d ? '0 : raw_sel;
    dis_d  = sel_d[V_DISMISS] | sel_d[V_DISRST] | sel_d[V_XRSTDIS];
    halt_d = sel_d[V_HALT];
  end

  jmpdec_outreg #(.NV(NUM_VAR)) u_out (
    .clk(clk), .rst_n(rst_n), .en(insn_valid),
    .sel_d(sel_d), .trap_d(trap_d), .dis_d(dis_d), .halt_d(halt_d),
    .vld_q(out_valid), .sel_q(sel), .trap_q(trap),
    .dis_q(dismiss_req), .halt_q(halt_req)
  );

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |=> out_valid);
  // R4
  undef_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && (sub_code == 4'd3 || sub_code == 4'd9 || sub_code == 4'd11 ||
                    sub_code == 4'd14 || sub_code == 4'd15)) |=> trap);
  // R10
  section_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && nz_section && (sub_code == 4'd2 || sub_code == 4'd10)) |=> trap);
endmodule

// File: tb/tb_jmpdec_top.sv
module tb_jmpdec_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [3:0]  sub_code;
  logic        user, uio, public, nz_section, rule_full;
  logic        out_valid, trap, dismiss_req, halt_req;
  logic [10:0] sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jmpdec_top dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .sub_code(sub_code),
    .user(user), .uio(uio), .public(public), .nz_section(nz_section),
    .rule_full(rule_full), .out_valid(out_valid), .sel(sel), .trap(trap),
    .dismiss_req(dismiss_req), .halt_req(halt_req)
  );

  // expected {out_valid, halt, dismiss, trap, sel[10:0]}
  function automatic logic [14:0] model(input logic v, input logic [3:0] c,
                                        input logic u, input logic io,
                                        input logic p, input logic nz,
                                        input logic full);
    int  idx;
    bit  ok;
    logic [10:0] s;
    logic bad_io;
    if (!v) return '0;                                  // R2
    bad_io = (u && !io) || (full && !u && p);
    ok = 1'b1;
    case (c)                                            // R3
      4'd0:  idx = 0;
      4'd1:  idx = 1;
      4'd2:  begin idx = 2;  ok = !nz; end              // R10
      4'd4:  begin idx = 3;  ok = !u && !(full && p); end // R6
      4'd5:  idx = 4;
      4'd6:  begin idx = 5;  ok = full ? !bad_io : !u; end // R8
      4'd7:  begin idx = 6;  ok = full ? !bad_io : !u; end
      4'd8:  begin idx = 7;  ok = !bad_io; end          // R7
      4'd10: begin idx = 8;  ok = !bad_io && !nz; end
      4'd12: begin idx = 9;  ok = full || !u; end       // R9
      4'd13: idx = 10;                                  // R11
      default: begin idx = 0; ok = 1'b0; end            // R4
    endcase
    if (!ok) return {1'b1, 1'b0, 1'b0, 1'b1, 11'd0};    // R5
    s = 11'd1 << idx;
    return {1'b1, s[3], (s[5] | s[7] | s[8]), 1'b0, s};
  endfunction

  function automatic string req_of(input logic v, input logic [3:0] c);
    if (!v) return "R2";
    case (c)
      4'd2:        return "R10";
      4'd4:        return "R6";
      4'd6, 4'd7:  return "R8";
      4'd8, 4'd10: return "R7";
      4'd12:       return "R9";
      4'd0, 4'd1, 4'd5, 4'd13: return "R11";
      default:     return "R4";
    endcase
  endfunction

  logic [14:0] exp_q;
  string       req_q;

  task automatic check_now(input logic [14:0] e, input string r);
    logic [14:0] got;
    got = {out_valid, halt_req, dismiss_req, trap, sel};
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, got, e);
    end
  endtask

  // check the previous vector, then drive the next one
  task automatic step(input logic v, input logic [3:0] c, input logic [4:0] f);
    @(negedge clk);
    check_now(exp_q, req_q);
    insn_valid = v; sub_code = c;
    {user, uio, public, nz_section, rule_full} = f;
    exp_q = model(v, c, f[4], f[3], f[2], f[1], f[0]);
    req_q = req_of(v, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5381));
    rst_n = 1'b0; insn_valid = 1'b1; sub_code = 4'd4;
    {user, uio, public, nz_section, rule_full} = '0;
    repeat (2) @(negedge clk);
    check_now('0, "R1");                       // R1 during reset
    @(negedge clk);
    rst_n = 1'b1; insn_valid = 1'b0;
    exp_q = '0; req_q = "R1";
    // full sweep: all codes x all flag/rule combinations
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        step(1'b1, 4'(c), 5'(f));
    // directed: code 10 denied for both reasons at once (R7 with R10)
    step(1'b1, 4'd10, 5'b10011);
    step(1'b0, 4'd10, 5'b00000);               // R2 idle after strobe
    step(1'b1, 4'd4, 5'b00001);                // R6 legal halt, full rules
    step(1'b1, 4'd4, 5'b00101);                // R6 public blocks halt
    step(1'b1, 4'd12, 5'b10001);               // R9 user ok under full rules
    // random mix including idle cycles
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 3) != 0), 4'($urandom), 5'($urandom));
    step(1'b0, 4'd0, 5'b0);
    step(1'b0, 4'd0, 5'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule